// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block decides where the processor goes when an exception is taken, and which state it saves on the way in. It is given a one-cycle request with an exception kind and a snapshot of the relevant processor state. That state is the current PC, the delay-slot and compact-ISA flags, the three status bits (exception level, error level, bootstrap vectors), the exception base register, the interrupt pending and mask bits, the vectored-interrupt controls and the TLB refill flag. On the next clock edge it presents the handler address, the saved return address, the cause code, the branch-delay bit and the new status bits. Each register update comes with its own write strobe.

Exceptions fall into three classes. General exceptions go through the programmable vector base. Error-class events (NMI, soft reset) use the fixed reset vector and the error return register. Debug-class events use the fixed debug vector and the debug return register. The surrounding core owns the architectural registers. It applies the values this block presents on the cycle the strobes are high. The request is a plain control pulse with no back-pressure, so a new request may arrive on any cycle.

Top module: `exv_entry`

## Requirements
- R1: The kind input `exc_kind` uses these codes for general exceptions, and each also becomes the 5-bit cause code: interrupt 0, TLB modify 1, TLB load 2, TLB store 3, address error load 4, address error store 5, instruction bus error 6, data bus error 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, watch 23, machine check 24, cache error 30. For a general exception `cause_wr` is 1 and `cause_code` equals the kind. Codes 16 (NMI), 17 (soft reset), 20 (debug event) and 21 (debug single step) are the special kinds. Any other code is ignored, and `ent_valid` stays 0.
- R2: A general exception jumps to base + offset. The base is 0xBFC00200 when `st_bev` is 1, and otherwise `ebase` with bits 9:0 cleared. The default offset is 0x180.
- R3: A TLB load or TLB store with `tlb_refill` = 1 and `st_exl` = 0 uses offset 0x000. With `st_exl` = 1 it uses 0x180.
- R4: An interrupt with `vint_en` = 0 uses offset 0x200 when `cause_iv` is 1, and 0x180 otherwise.
- R5: An interrupt with `vint_en` = 1 takes the highest set bit, from 7 down to 1, of `irq_pend & irq_mask` as the vector number. The number is 0 if none of those bits is set, and bit 0 never selects a vector. The offset is 0x200 + vector × (`vec_space` << 5).
- R6: A cache error uses offset 0x100 when `st_bev` is 1, and 0x20000100 otherwise, added to the R2 base.
- R7: For a general exception with `st_exl` = 0, the block asserts `epc_wr` and `bd_wr` with `bd_val` = `in_dslot`, and asserts `ksu_clr`. With `st_exl` = 1 none of these three strobes is asserted. `new_exl` is 1 after any general exception.
- R8: The return address is the PC with bit 0 ORed with `compact`. When `in_dslot` is 1, 2 is subtracted from it if `br16` is 1 and 4 otherwise. It is presented on `epc_val`, `errepc_val` or `depc_val`.
- R9: NMI and soft reset assert `errepc_wr` and set `new_erl` and `new_bev`. They jump to 0xBFC00000 and write no cause code. Their `bd_wr` equals NOT `st_exl`, with `bd_val` 0.
- R10: Debug kinds assert `depc_wr` and jump to 0xBFC00480, leaving `new_exl`, `new_erl` and `new_bev` equal to the incoming bits. For single step, `depc_val` is the PC with bit 0 ORed with `compact` and no delay-slot adjustment.
- R11: Results appear on the clock edge after the request. `ent_valid` and all strobes are high for that single cycle, and the value outputs hold until the next accepted request.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_kind | input | 5 | Exception kind code (R1) |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction sits in a branch delay slot |
| br16 | input | 1 | The branch before the slot is 16 bits long |
| compact | input | 1 | Compact-ISA mode is active |
| st_exl | input | 1 | Current exception-level bit |
| st_erl | input | 1 | Current error-level bit |
| st_bev | input | 1 | Current bootstrap-vector bit |
| ebase | input | 32 | Exception base register |
| cause_iv | input | 1 | Interrupts use the dedicated 0x200 offset |
| irq_pend | input | 8 | Interrupt pending bits |
| irq_mask | input | 8 | Interrupt mask bits |
| vint_en | input | 1 | Vectored interrupt mode |
| vec_space | input | 5 | Vector spacing field |
| tlb_refill | input | 1 | TLB exception is a refill (no matching entry) |
| ent_valid | output | 1 | Entry results valid this cycle |
| next_pc | output | 32 | Handler address |
| epc_wr | output | 1 | Write strobe for the exception return register |
| epc_val | output | 32 | New exception return address |
| errepc_wr | output | 1 | Write strobe for the error return register |
| errepc_val | output | 32 | New error return address |
| depc_wr | output | 1 | Write strobe for the debug return register |
| depc_val | output | 32 | New debug return address |
| cause_wr | output | 1 | Write strobe for the cause code |
| cause_code | output | 5 | New cause code |
| bd_wr | output | 1 | Write strobe for the branch-delay bit |
| bd_val | output | 1 | New branch-delay bit |
| ksu_clr | output | 1 | Force privilege to kernel |
| new_exl | output | 1 | Updated exception-level bit |
| new_erl | output | 1 | Updated error-level bit |
| new_bev | output | 1 | Updated bootstrap-vector bit |

## Verification
The hardest case to reach is the vectored interrupt, whose offset depends at once on the priority among masked pending bits and on the spacing field. Random pending and mask bytes seldom leave bit 0 as the only survivor, or leave only the top line set. The stimulus therefore mixes fully random interrupt state with directed patterns for those two cases. Refill and cache-error offsets also depend on the status bits, so directed cases cover both values of exception level and bootstrap-vector.

// File: rtl/exv_pkg.sv
package exv_pkg;

  typedef enum logic [4:0] {
    EK_INT    = 5'd0,
    EK_TLBMOD = 5'd1,
    EK_TLBLD  = 5'd2,
    EK_TLBST  = 5'd3,
    EK_ADEL   = 5'd4,
    EK_ADES   = 5'd5,
    EK_IBUS   = 5'd6,
    EK_DBUS   = 5'd7,
    EK_SYS    = 5'd8,
    EK_BRK    = 5'd9,
    EK_RSVD   = 5'd10,
    EK_COPUN  = 5'd11,
    EK_OVF    = 5'd12,
    EK_TRAP   = 5'd13,
    EK_FPE    = 5'd15,
    EK_NMI    = 5'd16,
    EK_SRST   = 5'd17,
    EK_DBG    = 5'd20,
    EK_DSTEP  = 5'd21,
    EK_WATCH  = 5'd23,
    EK_MCHK   = 5'd24,
    EK_CACHE  = 5'd30
  } exc_kind_e;

  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_GEN  = 2'd1,
    CL_ERR  = 2'd2,
    CL_DBG  = 2'd3
  } exc_class_e;

  localparam logic [31:0] VEC_BOOT_GEN  = 32'hBFC0_0200;
  localparam logic [31:0] VEC_RESET     = 32'hBFC0_0000;
  localparam logic [31:0] VEC_DEBUG     = 32'hBFC0_0480;
  localparam logic [31:0] OFF_GENERAL   = 32'h0000_0180;
  localparam logic [31:0] OFF_REFILL    = 32'h0000_0000;
  localparam logic [31:0] OFF_IRQ       = 32'h0000_0200;
  localparam logic [31:0] OFF_CERR_BOOT = 32'h0000_0100;
  localparam logic [31:0] OFF_CERR_RUN  = 32'h2000_0100;
  localparam int          BASE_ALIGN    = 10;

endpackage

// File: rtl/exv_classify.sv
module exv_classify
  import exv_pkg::*;
(
  input  logic [4:0]  kind,
  output exc_class_e  cls,
  output logic        is_intr,
  output logic        is_tlb_ls,
  output logic        is_cache,
  output logic        is_dstep
);

  always_comb begin
    cls = CL_NONE;
    case (kind)
      EK_INT, EK_TLBMOD, EK_TLBLD, EK_TLBST, EK_ADEL, EK_ADES,
      EK_IBUS, EK_DBUS, EK_SYS, EK_BRK, EK_RSVD, EK_COPUN,
      EK_OVF, EK_TRAP, EK_FPE, EK_WATCH, EK_MCHK, EK_CACHE:
        cls = CL_GEN;
      EK_NMI, EK_SRST:
        cls = CL_ERR;
      EK_DBG, EK_DSTEP:
        cls = CL_DBG;
      default:
        cls = CL_NONE;
    endcase
  end

  assign is_intr   = (kind == EK_INT);
  assign is_tlb_ls = (kind == EK_TLBLD) || (kind == EK_TLBST);
  assign is_cache  = (kind == EK_CACHE);
  assign is_dstep  = (kind == EK_DSTEP);

endmodule

// File: rtl/exv_resume_pc.sv
module exv_resume_pc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic            compact,
  input  logic            in_dslot,
  input  logic            br16,
  output logic [XLEN-1:0] tagged_pc,
  output logic [XLEN-1:0] resume_pc
);

  localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);
  localparam logic [XLEN-1:0] STEP_LONG  = XLEN'(4);

  logic [XLEN-1:0] back_step;

  assign tagged_pc = {pc[XLEN-1:1], pc[0] | compact};
  assign back_step = !in_dslot ? '0 : (br16 ? STEP_SHORT : STEP_LONG);
  assign resume_pc = tagged_pc - back_step;

endmodule

// File: rtl/exv_irq_vector.sv
module exv_irq_vector
  import exv_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IRQ_LINES = 8,
  parameter int VS_W      = 5
) (
  input  logic [IRQ_LINES-1:0] pend,
  input  logic [IRQ_LINES-1:0] mask,
  input  logic                 vint_en,
  input  logic                 iv,
  input  logic [VS_W-1:0]      space,
  output logic [XLEN-1:0]      offset
);

  localparam int VEC_W    = (IRQ_LINES > 1) ? $clog2(IRQ_LINES) : 1;
  localparam int SPACE_SH = 5;

  logic [IRQ_LINES-1:0] live;
  logic [VEC_W-1:0]     vec_num;
  logic [XLEN-1:0]      stride;

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_live
    assign live[g] = pend[g] & mask[g];
  end

  // ascending scan so the highest live line wins; line 0 never selects
  always_comb begin
    vec_num = '0;
    for (int i = 1; i < IRQ_LINES; i++) begin
      if (live[i]) vec_num = VEC_W'(i);
    end
  end

  assign stride = XLEN'(space) << SPACE_SH;

  always_comb begin
    if (vint_en)
      offset = OFF_IRQ + XLEN'(vec_num) * stride;
    else if (iv)
      offset = OFF_IRQ;
    else
      offset = OFF_GENERAL;
  end

endmodule

// File: rtl/exv_entry.sv
module exv_entry
  import exv_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IRQ_LINES = 8,
  parameter int VS_W      = 5,
  parameter int CODE_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_kind,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              in_dslot,
  input  logic              br16,
  input  logic              compact,
  input  logic              st_exl,
  input  logic              st_erl,
  input  logic              st_bev,
  input  logic [XLEN-1:0]   ebase,
  input  logic              cause_iv,
  input  logic [IRQ_LINES-1:0] irq_pend,
  input  logic [IRQ_LINES-1:0] irq_mask,
  input  logic              vint_en,
  input  logic [VS_W-1:0]   vec_space,
  input  logic              tlb_refill,
  output logic              ent_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              epc_wr,
  output logic [XLEN-1:0]   epc_val,
  output logic              errepc_wr,
  output logic [XLEN-1:0]   errepc_val,
  output logic              depc_wr,
  output logic [XLEN-1:0]   depc_val,
  output logic              cause_wr,
  output logic [CODE_W-1:0] cause_code,
  output logic              bd_wr,
  output logic              bd_val,
  output logic              ksu_clr,
  output logic              new_exl,
  output logic              new_erl,
  output logic              new_bev
);

  exc_class_e      cls;
  logic            k_intr, k_tlb, k_cache, k_dstep;
  logic [XLEN-1:0] tagged_pc, resume_pc;
  logic [XLEN-1:0] irq_off, gen_off, gen_base, target;
  logic            take;

  exv_classify u_cls (
    .kind      (exc_kind),
    .cls       (cls),
    .is_intr   (k_intr),
    .is_tlb_ls (k_tlb),
    .is_cache  (k_cache),
    .is_dstep  (k_dstep)
  );

  exv_resume_pc #(.XLEN(XLEN)) u_rpc (
    .pc        (cur_pc),
    .compact   (compact),
    .in_dslot  (in_dslot),
    .br16      (br16),
    .tagged_pc (tagged_pc),
    .resume_pc (resume_pc)
  );

  exv_irq_vector #(.XLEN(XLEN), .IRQ_LINES(IRQ_LINES), .VS_W(VS_W)) u_irq (
    .pend    (irq_pend),
    .mask    (irq_mask),
    .vint_en (vint_en),
    .iv      (cause_iv),
    .space   (vec_space),
    .offset  (irq_off)
  );

  // general-class base and offset selection
  assign gen_base = st_bev ? VEC_BOOT_GEN
                           : {ebase[XLEN-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};

  always_comb begin
    if (k_intr)
      gen_off = irq_off;
    else if (k_tlb && tlb_refill && !st_exl)
      gen_off = OFF_REFILL;
    else if (k_cache)
      gen_off = st_bev ? OFF_CERR_BOOT : OFF_CERR_RUN;
    else
      gen_off = OFF_GENERAL;
  end

  always_comb begin
    case (cls)
      CL_ERR:  target = VEC_RESET;
      CL_DBG:  target = VEC_DEBUG;
      default: target = gen_base + gen_off;
    endcase
  end

  assign take = exc_req && (cls != CL_NONE);

  // strobes: high for the single cycle after an accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= 1'b0;
      epc_wr    <= 1'b0;
      errepc_wr <= 1'b0;
      depc_wr   <= 1'b0;
      cause_wr  <= 1'b0;
      bd_wr     <= 1'b0;
      ksu_clr   <= 1'b0;
    end else begin
      ent_valid <= take;
      epc_wr    <= take && (cls == CL_GEN) && !st_exl;
      errepc_wr <= take && (cls == CL_ERR);
      depc_wr   <= take && (cls == CL_DBG);
      cause_wr  <= take && (cls == CL_GEN);
      bd_wr     <= take && !st_exl;
      ksu_clr   <= take && ((cls != CL_GEN) || !st_exl);
    end
  end

  // values: updated on an accepted request, held otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc    <= '0;
      epc_val    <= '0;
      errepc_val <= '0;
      depc_val   <= '0;
      cause_code <= '0;
      bd_val     <= 1'b0;
      new_exl    <= 1'b0;
      new_erl    <= 1'b0;
      new_bev    <= 1'b0;
    end else if (take) begin
      next_pc <= target;
      case (cls)
        CL_GEN: begin
          cause_code <= exc_kind;
          if (!st_exl) begin
            epc_val <= resume_pc;
            bd_val  <= in_dslot;
          end
          new_exl <= 1'b1;
          new_erl <= st_erl;
          new_bev <= st_bev;
        end
        CL_ERR: begin
          errepc_val <= resume_pc;
          bd_val     <= 1'b0;
          new_exl    <= st_exl;
          new_erl    <= 1'b1;
          new_bev    <= 1'b1;
        end
        default: begin
          depc_val <= k_dstep ? tagged_pc : resume_pc;
          bd_val   <= 1'b0;
          new_exl  <= st_exl;
          new_erl  <= st_erl;
          new_bev  <= st_bev;
        end
      endcase
    end
  end

endmodule

// File: rtl/exv_entry_chk.sv
module exv_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic            st_exl,
  input logic            ent_valid,
  input logic [XLEN-1:0] next_pc,
  input logic            epc_wr,
  input logic            errepc_wr,
  input logic            depc_wr,
  input logic            cause_wr,
  input logic            bd_wr,
  input logic            ksu_clr,
  input logic            new_exl,
  input logic            new_erl,
  input logic            new_bev
);

  AST_ENTRY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) ent_valid |-> $past(exc_req)); // R11
  AST_STROBE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (epc_wr || errepc_wr || depc_wr || cause_wr || bd_wr || ksu_clr) |-> ent_valid); // R11
  AST_ONE_RETURN_REG: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({epc_wr, errepc_wr, depc_wr})); // R1
  AST_EPC_ONLY_FROM_BASE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) epc_wr |-> !$past(st_exl)); // R7
  AST_GENERAL_SETS_EXL: assert property (@(posedge clk) disable iff (!rst_n) cause_wr |-> new_exl); // R7
  AST_ERROR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) errepc_wr |-> (new_erl && new_bev && next_pc == XLEN'(32'hBFC0_0000))); // R9
  AST_DEBUG_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) depc_wr |-> (next_pc == XLEN'(32'hBFC0_0480) && !cause_wr)); // R10
  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) ent_valid |-> (next_pc[1:0] == 2'b00)); // R2

endmodule

bind exv_entry exv_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_req   (exc_req),
  .st_exl    (st_exl),
  .ent_valid (ent_valid),
  .next_pc   (next_pc),
  .epc_wr    (epc_wr),
  .errepc_wr (errepc_wr),
  .depc_wr   (depc_wr),
  .cause_wr  (cause_wr),
  .bd_wr     (bd_wr),
  .ksu_clr   (ksu_clr),
  .new_exl   (new_exl),
  .new_erl   (new_erl),
  .new_bev   (new_bev)
);

// File: tb/exv_entry_tb.sv
`timescale 1ns/1ps
module exv_entry_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_kind = '0;
  logic [31:0] cur_pc = '0;
  logic        in_dslot = 1'b0, br16 = 1'b0, compact = 1'b0;
  logic        st_exl = 1'b0, st_erl = 1'b0, st_bev = 1'b0;
  logic [31:0] ebase = '0;
  logic        cause_iv = 1'b0;
  logic [7:0]  irq_pend = '0, irq_mask = '0;
  logic        vint_en = 1'b0;
  logic [4:0]  vec_space = '0;
  logic        tlb_refill = 1'b0;

  logic        ent_valid, epc_wr, errepc_wr, depc_wr, cause_wr, bd_wr, bd_val, ksu_clr;
  logic        new_exl, new_erl, new_bev;
  logic [31:0] next_pc, epc_val, errepc_val, depc_val;
  logic [4:0]  cause_code;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  exv_entry u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_kind(exc_kind),
    .cur_pc(cur_pc), .in_dslot(in_dslot), .br16(br16), .compact(compact),
    .st_exl(st_exl), .st_erl(st_erl), .st_bev(st_bev), .ebase(ebase),
    .cause_iv(cause_iv), .irq_pend(irq_pend), .irq_mask(irq_mask),
    .vint_en(vint_en), .vec_space(vec_space), .tlb_refill(tlb_refill),
    .ent_valid(ent_valid), .next_pc(next_pc), .epc_wr(epc_wr), .epc_val(epc_val),
    .errepc_wr(errepc_wr), .errepc_val(errepc_val), .depc_wr(depc_wr),
    .depc_val(depc_val), .cause_wr(cause_wr), .cause_code(cause_code),
    .bd_wr(bd_wr), .bd_val(bd_val), .ksu_clr(ksu_clr),
    .new_exl(new_exl), .new_erl(new_erl), .new_bev(new_bev)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // 0 ignored, 1 general, 2 error class, 3 debug class
  function automatic int kind_class(input logic [4:0] k);
    case (k)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9,
      5'd10, 5'd11, 5'd12, 5'd13, 5'd15, 5'd23, 5'd24, 5'd30: return 1;
      5'd16, 5'd17: return 2;
      5'd20, 5'd21: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_tagged();
    return cur_pc | {31'd0, compact};
  endfunction

  function automatic logic [31:0] model_resume();
    logic [31:0] r = model_tagged();
    if (in_dslot) r = r - (br16 ? 32'd2 : 32'd4);
    return r;
  endfunction

  function automatic logic [31:0] model_irq_off();
    logic [7:0] live = irq_pend & irq_mask;
    int v = 0;
    if (!vint_en) return cause_iv ? 32'h200 : 32'h180;
    for (int i = 7; i >= 1; i--) begin
      if (live[i] && v == 0) v = i;
    end
    return 32'h200 + 32'(v) * (32'(vec_space) * 32);
  endfunction

  function automatic logic [31:0] model_target(output string tag);
    logic [31:0] base, off;
    int c = kind_class(exc_kind);
    if (c == 2) begin tag = "R9"; return 32'hBFC0_0000; end
    if (c == 3) begin tag = "R10"; return 32'hBFC0_0480; end
    base = st_bev ? 32'hBFC0_0200 : {ebase[31:10], 10'd0};
    tag = "R2";
    off = 32'h180;
    if (exc_kind == 5'd0) begin
      off = model_irq_off();
      tag = vint_en ? "R5" : "R4";
    end else if ((exc_kind == 5'd2 || exc_kind == 5'd3) && tlb_refill) begin
      tag = "R3";
      off = st_exl ? 32'h180 : 32'h0;
    end else if (exc_kind == 5'd30) begin
      tag = "R6";
      off = st_bev ? 32'h100 : 32'h2000_0100;
    end
    return base + off;
  endfunction

  task automatic run_one();
    string       tag;
    int          c = kind_class(exc_kind);
    logic [31:0] exp_pc = model_target(tag);
    logic [31:0] exp_rpc = model_resume();
    logic [31:0] exp_tag = model_tagged();
    logic [31:0] prev_epc;
    logic        s_exl = st_exl, s_erl = st_erl, s_bev = st_bev, s_ds = in_dslot;
    logic [4:0]  k = exc_kind;
    exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
    if (c == 0) begin
      chk("R1", "ignored kind ent_valid", 32'(ent_valid), 0);
      chk("R1", "ignored kind cause_wr", 32'(cause_wr), 0);
    end else begin
      chk("R11", "ent_valid", 32'(ent_valid), 1);
      chk(tag, "next_pc", next_pc, exp_pc);
      chk("R7", "ksu_clr", 32'(ksu_clr), (c != 1 || !s_exl) ? 1 : 0);
      if (c == 1) begin
        chk("R1", "cause_wr", 32'(cause_wr), 1);
        chk("R1", "cause_code", 32'(cause_code), 32'(k));
        chk("R7", "epc_wr", 32'(epc_wr), s_exl ? 0 : 1);
        chk("R7", "bd_wr", 32'(bd_wr), s_exl ? 0 : 1);
        chk("R7", "new_exl", 32'(new_exl), 1);
        if (!s_exl) begin
          chk("R8", "epc_val", epc_val, exp_rpc);
          chk("R7", "bd_val", 32'(bd_val), 32'(s_ds));
        end
      end else if (c == 2) begin
        chk("R9", "errepc_wr", 32'(errepc_wr), 1);
        chk("R9", "errepc_val", errepc_val, exp_rpc);
        chk("R9", "new_erl/bev", {30'd0, new_erl, new_bev}, 32'd3);
        chk("R9", "cause_wr", 32'(cause_wr), 0);
        chk("R9", "bd_wr/bd_val", {30'd0, bd_wr, bd_val}, {30'd0, !s_exl, 1'b0});
      end else begin
        chk("R10", "depc_wr", 32'(depc_wr), 1);
        chk("R10", "depc_val", depc_val, (k == 5'd21) ? exp_tag : exp_rpc);
        chk("R10", "status kept", {29'd0, new_exl, new_erl, new_bev}, {29'd0, s_exl, s_erl, s_bev});
      end
    end
    prev_epc = epc_val;
    @(negedge clk);
    chk("R11", "strobes drop", {26'd0, ent_valid, epc_wr, errepc_wr, depc_wr, cause_wr, bd_wr}, 0);
    chk("R11", "epc_val held", epc_val, prev_epc);
  endtask

  task automatic clear_state();
    in_dslot = 0; br16 = 0; compact = 0; st_exl = 0; st_erl = 0; st_bev = 0;
    cause_iv = 0; vint_en = 0; tlb_refill = 0; irq_pend = 0; irq_mask = 0;
    vec_space = 0; ebase = 32'h8000_13FF; cur_pc = 32'h8000_2000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] kinds [0:21];
    int seed = 32'h5EED_1234;
    void'($urandom(seed));
    kinds = '{5'd0,5'd1,5'd2,5'd3,5'd4,5'd5,5'd6,5'd7,5'd8,5'd9,5'd10,
              5'd11,5'd12,5'd13,5'd15,5'd23,5'd24,5'd30,5'd16,5'd17,5'd20,5'd21};

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "ent_valid", 32'(ent_valid), 0);
    chk("R12", "next_pc", next_pc, 0);
    chk("R12", "epc_val", epc_val, 0);
    chk("R12", "status", {29'd0, new_exl, new_erl, new_bev}, 0);
    chk("R12", "cause_code", 32'(cause_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    clear_state(); exc_kind = 5'd8; run_one();                          // R2 base from ebase
    clear_state(); st_bev = 1; exc_kind = 5'd12; run_one();             // R2 boot base
    clear_state(); exc_kind = 5'd2; tlb_refill = 1; run_one();          // R3 refill
    clear_state(); exc_kind = 5'd3; tlb_refill = 1; st_exl = 1; run_one(); // R3 with EXL set
    clear_state(); exc_kind = 5'd0; cause_iv = 1; run_one();            // R4
    clear_state(); exc_kind = 5'd0; run_one();                          // R4 no IV
    clear_state(); exc_kind = 5'd0; vint_en = 1; vec_space = 5'd1;
    irq_pend = 8'h01; irq_mask = 8'hFF; run_one();                      // R5 only line 0
    clear_state(); exc_kind = 5'd0; vint_en = 1; vec_space = 5'd31;
    irq_pend = 8'hFF; irq_mask = 8'h81; run_one();                      // R5 top line
    clear_state(); exc_kind = 5'd0; vint_en = 1; vec_space = 5'd2;
    irq_pend = 8'h2C; irq_mask = 8'h1E; run_one();                      // R5 mask picks line 3
    clear_state(); exc_kind = 5'd30; run_one();                         // R6 run-time
    clear_state(); exc_kind = 5'd30; st_bev = 1; run_one();             // R6 boot
    clear_state(); exc_kind = 5'd9; st_exl = 1; in_dslot = 1; run_one(); // R7 nested
    clear_state(); exc_kind = 5'd4; in_dslot = 1; run_one();            // R8 long branch
    clear_state(); exc_kind = 5'd5; in_dslot = 1; br16 = 1; compact = 1; run_one(); // R8 short
    clear_state(); exc_kind = 5'd16; in_dslot = 1; run_one();           // R9 NMI
    clear_state(); exc_kind = 5'd17; st_exl = 1; run_one();             // R9 soft reset
    clear_state(); exc_kind = 5'd21; in_dslot = 1; compact = 1; run_one(); // R10 single step
    clear_state(); exc_kind = 5'd20; in_dslot = 1; st_erl = 1; run_one();  // R10 debug
    clear_state(); exc_kind = 5'd14; run_one();                         // R1 ignored kind
    clear_state(); exc_kind = 5'd31; run_one();                         // R1 ignored kind

    // random mix
    for (int n = 0; n < 600; n++) begin
      int pick = $urandom_range(0, 24);
      exc_kind   = (pick < 22) ? kinds[pick] : 5'($urandom_range(0, 31));
      cur_pc     = {$urandom()} & 32'hFFFF_FFFE;
      compact    = 1'($urandom());
      in_dslot   = 1'($urandom());
      br16       = 1'($urandom());
      st_exl     = 1'($urandom());
      st_erl     = 1'($urandom());
      st_bev     = 1'($urandom());
      ebase      = $urandom();
      cause_iv   = 1'($urandom());
      irq_pend   = 8'($urandom());
      irq_mask   = 8'($urandom());
      vint_en    = 1'($urandom());
      vec_space  = 5'($urandom());
      tlb_refill = 1'($urandom());
      run_one();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule